// File: doc/BRIEF.md
# Sector Protection Gate

This block sits in front of the program and erase engine of a word-addressed non-volatile array. It splits the address into 4 Kword units and maps each unit to a sector number. The sector layout is non-uniform. Eight single-unit boot sectors sit at the bottom of the space and eight more at the top. Every sector between them covers eight units. The block keeps one protection flag per sector. For each program or erase request it returns exactly one verdict: grant or deny.

Two conditions can override the stored flags. The first is a three-level write-protect input, which arrives already decoded. At its low level it forces the two lowest and two highest sectors into protection. At its elevated level it lifts all protection. The second is a high-voltage condition on the reset pin, also pre-decoded. It lifts all protection only while it is present. Protect and unprotect strobes set or clear the stored flag of the addressed sector. A separate query port returns a status byte for any sector.

Top module: `secprot_unit`

## Requirements
- R1: The sector number is taken from the unit index u = addr_i[21:12]. For u below 8 the sector is u. For u of 1016 or more the sector is u - 882, which gives sectors 134 to 141. For any other u the sector is u/8 + 7, which gives sectors 8 to 133, each spanning eight units.
- R2: A cycle with prot_set_i high and prot_clr_i low marks the sector addressed by addr_i as protected. A single-sector request to a protected sector is then denied.
- R3: A cycle with prot_clr_i high and prot_set_i low clears that sector's flag. When both strobes are high in the same cycle, the flag keeps its value.
- R4: When wp_lvl_i is 2'b00 (low), sectors 0, 1, 140 and 141 count as protected whatever their flags hold. This does not apply while R6 or R7 unlocks the array.
- R5: When wp_lvl_i is 2'b01 (high), the four edge sectors follow their stored flags like any other sector. Code 2'b11 behaves as 2'b01.
- R6: When wp_lvl_i is 2'b10 (elevated), every sector counts as unprotected. The stored flags are not altered.
- R7: While rst_hv_i is high, every sector counts as unprotected. When it drops, the stored protection applies again.
- R8: A request is a cycle with op_valid_i high. Exactly one of grant_o and deny_o is high in the following cycle. Both are low after a cycle with no request.
- R9: When op_all_i is high, the request is a whole-array erase. It is granted when at least one sector counts as unprotected, and denied only when all 142 sectors count as protected.
- R10: qry_status_o shows 8'h01 when the sector addressed by qry_addr_i counts as protected, and 8'h00 when it does not. The value appears one cycle after the query address is presented.
- R11: The stored flags are kept through an rst_ni assertion. While rst_ni is low, all outputs are zero and the protect and unprotect strobes are ignored.
- R12: At power-on every sector flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the outputs |
| addr_i | input | 22 | Word address for requests and strobes |
| op_valid_i | input | 1 | Program or erase request |
| op_all_i | input | 1 | Request is a whole-array erase |
| prot_set_i | input | 1 | Protect the addressed sector |
| prot_clr_i | input | 1 | Unprotect the addressed sector |
| wp_lvl_i | input | 2 | Decoded write-protect level: 00 low, 01 high, 10 elevated, 11 as high |
| rst_hv_i | input | 1 | Reset pin at high voltage (temporary unprotect) |
| qry_addr_i | input | 22 | Address of the sector being queried |
| grant_o | output | 1 | Request granted |
| deny_o | output | 1 | Request denied |
| qry_status_o | output | 8 | Protection status of the queried sector |

## Verification
A verdict is registered once, so it is due in the cycle after the request. The query byte is also due one cycle after its address, and it already reflects a strobe issued in the cycle before the query. The bench drives every stimulus on the falling edge and samples on the next falling edge. That places each check exactly one rising edge after its cause. Strobes are made in their own cycle before any request or query that depends on them. This keeps the one-cycle flag write apart from the verdict timing.

// File: rtl/secprot_pkg.sv
package secprot_pkg;
  typedef enum logic [1:0] {
    WP_LOW   = 2'b00,
    WP_HIGH  = 2'b01,
    WP_ACCEL = 2'b10,
    WP_RSVD  = 2'b11
  } wp_lvl_e;
endpackage

// File: rtl/secprot_map.sv
module secprot_map #(
  parameter int UNIT_W    = 10,
  parameter int BOOT_CNT  = 8,
  parameter int BIG_UNITS = 8,
  parameter int SECT_W    = 8
) (
  input  logic [UNIT_W-1:0] unit_i,
  output logic [SECT_W-1:0] sect_o
);
  localparam int NUM_UNITS = 1 << UNIT_W;
  localparam int BIG_CNT   = (NUM_UNITS - 2*BOOT_CNT) / BIG_UNITS;
  localparam logic [UNIT_W-1:0] LO_END = UNIT_W'(BOOT_CNT);
  localparam logic [UNIT_W-1:0] HI_BEG = UNIT_W'(NUM_UNITS - BOOT_CNT);
  localparam logic [UNIT_W-1:0] HI_OFS = UNIT_W'(BOOT_CNT + BIG_CNT);

  logic [UNIT_W-1:0] idx;

  always_comb begin
    if (unit_i < LO_END)        idx = unit_i;
    else if (unit_i >= HI_BEG)  idx = unit_i - HI_BEG + HI_OFS;
    else                        idx = UNIT_W'((unit_i - LO_END) / UNIT_W'(BIG_UNITS)) + LO_END;
  end

  assign sect_o = idx[SECT_W-1:0];
endmodule

// File: rtl/secprot_store.sv
module secprot_store #(
  parameter int NUM_SECT = 142,
  parameter int SECT_W   = 8,
  parameter int WP_EDGE  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SECT_W-1:0]   sect_i,
  input  logic                set_i,
  input  logic                clr_i,
  input  logic                force_i,
  input  logic                unlock_i,
  output logic [NUM_SECT-1:0] eff_o
);
  // flags carry no reset: they must outlive rst_ni
  logic [NUM_SECT-1:0] flag_q = '0;

  always_ff @(posedge clk_i) begin
    if (rst_ni && (set_i != clr_i)) flag_q[sect_i] <= set_i;
  end

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_eff
    localparam bit EDGE = (s < WP_EDGE) || (s >= NUM_SECT - WP_EDGE);
    assign eff_o[s] = !unlock_i && (flag_q[s] || (force_i && EDGE));
  end
endmodule

// File: rtl/secprot_gate.sv
module secprot_gate #(
  parameter int NUM_SECT = 142,
  parameter int SECT_W   = 8,
  parameter int STAT_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SECT-1:0] eff_i,
  input  logic                op_valid_i,
  input  logic                op_all_i,
  input  logic [SECT_W-1:0]   op_sect_i,
  input  logic [SECT_W-1:0]   qry_sect_i,
  output logic                grant_o,
  output logic                deny_o,
  output logic [STAT_W-1:0]   qry_status_o
);
  logic ok;

  always_comb begin
    if (op_all_i) ok = |(~eff_i);
    else          ok = !eff_i[op_sect_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o      <= 1'b0;
      deny_o       <= 1'b0;
      qry_status_o <= '0;
    end else begin
      grant_o      <= op_valid_i && ok;
      deny_o       <= op_valid_i && !ok;
      qry_status_o <= {{(STAT_W-1){1'b0}}, eff_i[qry_sect_i]};
    end
  end
endmodule

// File: rtl/secprot_unit.sv
module secprot_unit #(
  parameter int ADDR_W    = 22,
  parameter int UNIT_LSB  = 12,
  parameter int BOOT_CNT  = 8,
  parameter int BIG_UNITS = 8,
  parameter int WP_EDGE   = 2,
  parameter int STAT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              op_valid_i,
  input  logic              op_all_i,
  input  logic              prot_set_i,
  input  logic              prot_clr_i,
  input  logic [1:0]        wp_lvl_i,
  input  logic              rst_hv_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic [STAT_W-1:0] qry_status_o
);
  import secprot_pkg::*;

  localparam int UNIT_W   = ADDR_W - UNIT_LSB;
  localparam int BIG_CNT  = ((1 << UNIT_W) - 2*BOOT_CNT) / BIG_UNITS;
  localparam int NUM_SECT = 2*BOOT_CNT + BIG_CNT;
  localparam int SECT_W   = $clog2(NUM_SECT);

  logic [SECT_W-1:0]   op_sect, qry_sect;
  logic [NUM_SECT-1:0] eff;
  logic                force_edge, unlock_all;
  logic                unused_lo;

  assign unused_lo  = ^{addr_i[UNIT_LSB-1:0], qry_addr_i[UNIT_LSB-1:0]};
  assign force_edge = wp_lvl_e'(wp_lvl_i) == WP_LOW;
  assign unlock_all = (wp_lvl_e'(wp_lvl_i) == WP_ACCEL) || rst_hv_i;

  secprot_map #(.UNIT_W(UNIT_W), .BOOT_CNT(BOOT_CNT), .BIG_UNITS(BIG_UNITS), .SECT_W(SECT_W))
    u_map_op (.unit_i(addr_i[ADDR_W-1:UNIT_LSB]), .sect_o(op_sect));

  secprot_map #(.UNIT_W(UNIT_W), .BOOT_CNT(BOOT_CNT), .BIG_UNITS(BIG_UNITS), .SECT_W(SECT_W))
    u_map_qry (.unit_i(qry_addr_i[ADDR_W-1:UNIT_LSB]), .sect_o(qry_sect));

  secprot_store #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .WP_EDGE(WP_EDGE)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sect_i   (op_sect),
    .set_i    (prot_set_i),
    .clr_i    (prot_clr_i),
    .force_i  (force_edge),
    .unlock_i (unlock_all),
    .eff_o    (eff)
  );

  secprot_gate #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .STAT_W(STAT_W)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .eff_i        (eff),
    .op_valid_i   (op_valid_i),
    .op_all_i     (op_all_i),
    .op_sect_i    (op_sect),
    .qry_sect_i   (qry_sect),
    .grant_o      (grant_o),
    .deny_o       (deny_o),
    .qry_status_o (qry_status_o)
  );
endmodule

// File: rtl/secprot_chk.sv
module secprot_chk #(
  parameter int ADDR_W   = 22,
  parameter int UNIT_LSB = 12,
  parameter int STAT_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              op_valid_i,
  input logic              op_all_i,
  input logic [1:0]        wp_lvl_i,
  input logic              rst_hv_i,
  input logic              grant_o,
  input logic              deny_o,
  input logic [STAT_W-1:0] qry_status_o
);
  logic edge_sect;
  assign edge_sect = (addr_i[ADDR_W-1:UNIT_LSB+1] == '0) || (addr_i[ADDR_W-1:UNIT_LSB+1] == '1);

  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> (grant_o != deny_o)); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> (!grant_o && !deny_o)); // R8

  AST_ACCEL_GRANTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && wp_lvl_i == 2'b10) |=> grant_o); // R6

  AST_HV_GRANTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && rst_hv_i) |=> grant_o); // R7

  AST_WP_LOW_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !op_all_i && wp_lvl_i == 2'b00 && !rst_hv_i && edge_sect) |=> deny_o); // R4

  AST_QRY_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_status_o[STAT_W-1:1] == '0); // R10

  always_comb begin
    if (!rst_ni) AST_RST_QUIET: assert (!grant_o && !deny_o && qry_status_o == '0); // R11
  end
endmodule

bind secprot_unit secprot_chk #(.ADDR_W(ADDR_W), .UNIT_LSB(UNIT_LSB), .STAT_W(STAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .op_valid_i   (op_valid_i),
  .op_all_i     (op_all_i),
  .wp_lvl_i     (wp_lvl_i),
  .rst_hv_i     (rst_hv_i),
  .grant_o      (grant_o),
  .deny_o       (deny_o),
  .qry_status_o (qry_status_o)
);

// File: tb/secprot_unit_tb.sv
module secprot_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] addr = '0;
  logic        op_valid = 1'b0;
  logic        op_all = 1'b0;
  logic        pset = 1'b0;
  logic        pclr = 1'b0;
  logic [1:0]  wp = 2'b01;
  logic        hv = 1'b0;
  logic [21:0] qaddr = '0;
  logic        grant, deny;
  logic [7:0]  qstat;

  int nchk = 0;
  int nfail = 0;
  bit mflag [142];

  always #10 clk = ~clk;

  secprot_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .op_valid_i(op_valid), .op_all_i(op_all),
    .prot_set_i(pset), .prot_clr_i(pclr), .wp_lvl_i(wp), .rst_hv_i(hv),
    .qry_addr_i(qaddr), .grant_o(grant), .deny_o(deny), .qry_status_o(qstat)
  );

  function automatic logic [21:0] base_of(int s);
    int u;
    if (s < 8)         u = s;
    else if (s >= 134) u = 1016 + (s - 134);
    else               u = (s - 7) * 8;
    return 22'(u << 12);
  endfunction

  function automatic int sect_of(logic [21:0] a);
    int u = int'(a >> 12);
    if (u < 8)     return u;
    if (u >= 1016) return 134 + (u - 1016);
    return 8 + (u - 8) / 8;
  endfunction

  function automatic bit prot_eff(int s);
    if (wp == 2'b10 || hv) return 1'b0;
    if (wp == 2'b00 && (s < 2 || s > 139)) return 1'b1;
    return mflag[s];
  endfunction

  function automatic bit exp_grant(logic [21:0] a, bit all);
    if (!all) return !prot_eff(sect_of(a));
    for (int s = 0; s < 142; s++) if (!prot_eff(s)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(logic [21:0] a, bit s, bit c);
    addr = a; pset = s; pclr = c;
    @(negedge clk);
    pset = 1'b0; pclr = 1'b0;
    if (rst_n && s != c) mflag[sect_of(a)] = s;
  endtask

  task automatic op(string tag, logic [21:0] a, bit all);
    bit e;
    e = exp_grant(a, all);
    addr = a; op_valid = 1'b1; op_all = all;
    @(negedge clk);
    chk(tag, int'(grant), int'(e));
    chk(tag, int'(deny), int'(!e));
    op_valid = 1'b0; op_all = 1'b0;
  endtask

  task automatic query(string tag, logic [21:0] a);
    int e;
    e = prot_eff(sect_of(a)) ? 1 : 0;
    qaddr = a;
    @(negedge clk);
    chk(tag, int'(qstat), e);
  endtask

  task automatic t_power_on;
    chk("R11 grant in reset", int'(grant), 0);
    chk("R11 qry in reset", int'(qstat), 0);
    rst_n = 1'b1;
    @(negedge clk);
    query("R12 sect0", base_of(0));
    query("R12 sect70", base_of(70));
    query("R12 sect141", base_of(141));
  endtask

  task automatic t_map;
    strobe(22'h008000, 1, 0);
    op("R1 unit15 in sect8", 22'h00F000, 0);
    op("R1 unit16 sect9", 22'h010000, 0);
    op("R1 unit7 sect7", 22'h007FFF, 0);
    strobe(22'h008000, 0, 1);
    strobe(22'h3F0000, 1, 0);
    op("R1 top of sect133", 22'h3F7FFF, 0);
    op("R1 sect134 small", 22'h3F8000, 0);
    strobe(22'h3F0000, 0, 1);
    strobe(22'h3FD000, 1, 0);
    op("R1 sect139", 22'h3FD123, 0);
    op("R1 sect138", 22'h3FC000, 0);
    strobe(22'h3FD000, 0, 1);
  endtask

  task automatic t_set_clr;
    strobe(base_of(30), 1, 0);
    op("R2 deny protected", base_of(30) + 22'h123, 0);
    query("R10 protected", base_of(30));
    strobe(base_of(30), 1, 1);
    query("R3 both strobes no change", base_of(30));
    strobe(base_of(30), 0, 1);
    op("R3 grant after clear", base_of(30), 0);
    query("R10 unprotected", base_of(30));
    strobe(base_of(31), 1, 1);
    query("R3 both strobes keep clear", base_of(31));
  endtask

  task automatic t_wp;
    wp = 2'b00;
    op("R4 sect0", base_of(0), 0);
    op("R4 sect1", base_of(1), 0);
    op("R4 sect140", base_of(140), 0);
    op("R4 sect141", base_of(141), 0);
    op("R4 sect2 free", base_of(2), 0);
    op("R4 sect139 free", base_of(139), 0);
    query("R4 query sect1", base_of(1));
    wp = 2'b01;
    op("R5 sect0 flag clear", base_of(0), 0);
    strobe(base_of(140), 1, 0);
    op("R5 sect140 flag set", base_of(140), 0);
    wp = 2'b11;
    op("R5 code3 as high", base_of(140), 0);
    op("R5 code3 sect141", base_of(141), 0);
    wp = 2'b10;
    op("R6 accel grants", base_of(140), 0);
    query("R6 accel query", base_of(140));
    wp = 2'b00;
    strobe(base_of(140), 0, 1);
    op("R4 flag cleared still forced", base_of(140), 0);
    wp = 2'b01;
    op("R6 flags unchanged", base_of(140), 0);
  endtask

  task automatic t_hv;
    strobe(base_of(70), 1, 0);
    hv = 1'b1;
    op("R7 hv grants", base_of(70), 0);
    query("R7 hv query", base_of(70));
    wp = 2'b00;
    op("R7 hv beats wp low", base_of(0), 0);
    wp = 2'b01;
    hv = 1'b0;
    op("R7 restored", base_of(70), 0);
    strobe(base_of(70), 0, 1);
  endtask

  task automatic t_chip;
    for (int s = 0; s < 142; s++) strobe(base_of(s), 1, 0);
    op("R9 all protected", 22'h0, 1);
    strobe(base_of(100), 0, 1);
    op("R9 one free", 22'h0, 1);
    strobe(base_of(100), 1, 0);
    wp = 2'b10;
    op("R9 accel", 22'h0, 1);
    wp = 2'b01;
    hv = 1'b1;
    op("R9 hv", 22'h0, 1);
    hv = 1'b0;
    for (int s = 0; s < 142; s++) strobe(base_of(s), 0, 1);
    op("R9 all clear", 22'h0, 1);
  endtask

  task automatic t_reset_keep;
    strobe(base_of(50), 1, 0);
    rst_n = 1'b0;
    addr = base_of(60); pset = 1'b1; op_valid = 1'b1;
    @(negedge clk);
    chk("R11 grant low in reset", int'(grant), 0);
    chk("R11 deny low in reset", int'(deny), 0);
    pset = 1'b0; op_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    query("R11 flag kept", base_of(50));
    query("R11 strobe ignored in reset", base_of(60));
    strobe(base_of(50), 0, 1);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_power_on();
    t_map();
    t_set_clr();
    t_wp();
    t_hv();
    t_chip();
    t_reset_keep();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule